// File: doc/BRIEF.md
# Parallel Port Microsequencer Engine

This block runs short programs of fixed-format 32-bit microinstructions against a parallel port register block. A host puts a program into the instruction memory and a start address on `start_addr_i`, then pulses `start_i`. The engine fetches and executes instructions one at a time until it reaches a return instruction. It then drops `busy_o`, pulses `done_o` and holds a return code and an error flag.

The instruction set covers the following:
- read-modify-write and whole-byte writes of the port registers;
- masked register fetches into a byte buffer memory;
- repeated transfers that walk a buffer pointer;
- microsecond delays counted on an external tick;
- an 8-bit loop counter with decrement-and-branch;
- three kinds of status-conditional branch;
- one level of subroutine call.

Instruction word layout: opcode in bits 31:27, register select in bits 25:24, field A in 23:16, field B in 15:8 and field C in 7:0. Bit 26 is ignored. Register select 0 is the data register, 1 the status register (read-only) and 2 the control register. Instruction memory and buffer memory both have a one-cycle synchronous read. The register read data is combinational on the current select.

Top module: `pport_useq`

## Requirements
- R1: With the engine idle, a `start_i` pulse raises `busy_o` on the next cycle, and execution begins at `start_addr_i`. At the end, `done_o` is high for exactly one cycle with `busy_o` already low. `ret_code_o` and `err_o` hold their values until the next start. Each start clears the loop counter, the pointer and the call depth.
- R2: Opcode 3 writes `(reg | A) & ~B` to the register named by the select. Writes aimed at the status register (select 1) never assert `reg_we_o`.
- R3: Opcode 4 writes field A to the selected register.
- R4: Opcode 2 stores `reg & A` into buffer address C.
- R5: Opcode 17 repeats A times: write `buffer[ptr]` to the selected register, then step the pointer by one. Opcode 18 repeats A times: store `reg & B` at `buffer[ptr]`, then step the pointer by one. The pointer wraps at 8 bits. A count of 0 does nothing. Opcode 12 loads the pointer with C.
- R6: Opcode 6 loads the loop counter with C. Opcode 7 decrements the counter and branches while the result is nonzero.
- R7: Opcode 8 branches when any status bit selected by A is 1. Opcode 9 branches when any status bit selected by A is 0.
- R8: Opcode 14 branches only when all status bits in A are 1 and all status bits in B are 0.
- R9: A branch target is (index of the next instruction + C taken as signed 8-bit), modulo the instruction memory depth.
- R10: Opcode 16 jumps to the absolute index C and remembers the index after the call. Opcode 15 resumes execution there.
- R11: Each of the following ends execution with `err_o`=1 and `ret_code_o`=0: a call made while inside a subroutine, opcode 15 outside a subroutine, or any opcode not listed here.
- R12: Opcode 5 waits until `{B,C}` ticks of `tick_us_i` have been counted, then advances. A value of 0 advances at once.
- R13: Opcode 10 ends execution with `ret_code_o`=C and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| start_addr_i | input | IA_W | First instruction index |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle end pulse |
| ret_code_o | output | 8 | Return code of last run |
| err_o | output | 1 | Last run ended on a fault |
| imem_addr_o | output | IA_W | Instruction read address |
| imem_rdata_i | input | 32 | Instruction word, one cycle after the address |
| buf_addr_o | output | 8 | Buffer address |
| buf_we_o | output | 1 | Buffer write enable |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the address |
| reg_sel_o | output | 2 | Port register select |
| reg_we_o | output | 1 | Port register write enable |
| reg_wdata_o | output | 8 | Port register write data |
| reg_rdata_i | input | 8 | Selected port register value |
| tick_us_i | input | 1 | One-cycle microsecond tick |

## Verification
The assertions check every cycle that:
- the start/busy/done handshake is correct;
- the pointer steps by exactly one per repeated buffer write;
- the status register is never written;
- a second-level call faults at once;
- the delay counter never passes its target.

Only the bench scenarios can show that results are right. These include register and buffer contents after mixed programs, branch decisions against a given status value, loop trip counts, call/return resumption and the exact tick count of a delay. The bench compares each of these with an instruction-level model.

// File: rtl/pport_useq_pkg.sv
// Package: shared opcode, register-select and state types for the
// parallel port microsequencer. Assumes a 32-bit instruction word.
package pport_useq_pkg;

    localparam int IW = 32;

    typedef enum logic [4:0] {
        OP_FETCH   = 5'd2,
        OP_MODIFY  = 5'd3,
        OP_WRITE   = 5'd4,
        OP_DELAY   = 5'd5,
        OP_LDCNT   = 5'd6,
        OP_DECBR   = 5'd7,
        OP_BRANY1  = 5'd8,
        OP_BRANY0  = 5'd9,
        OP_RETURN  = 5'd10,
        OP_LDPTR   = 5'd12,
        OP_BRSTATE = 5'd14,
        OP_SUBRET  = 5'd15,
        OP_CALL    = 5'd16,
        OP_PWRITE  = 5'd17,
        OP_PFETCH  = 5'd18
    } op_e;

    localparam logic [1:0] SEL_STATUS = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_EXEC, ST_WAIT, ST_REP, ST_PWR
    } state_e;

endpackage

// File: rtl/useq_cond.sv
// Module: useq_cond
// Decides whether a status-conditional branch is taken. Purely
// combinational; non-branch opcodes yield not-taken.
module useq_cond
    import pport_useq_pkg::*;
(
    input  logic [4:0] op_i,
    input  logic [7:0] status_i,
    input  logic [7:0] mask_a_i,
    input  logic [7:0] mask_b_i,
    output logic       take_o
);

    // Branch condition per opcode
    always_comb begin
        unique case (op_i)
            OP_BRANY1:  take_o = |(status_i & mask_a_i);
            OP_BRANY0:  take_o = |(~status_i & mask_a_i);
            OP_BRSTATE: take_o = ((status_i & mask_a_i) == mask_a_i) &&
                                 ((status_i & mask_b_i) == 8'd0);
            default:    take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_delay.sv
// Module: useq_delay
// Counts microsecond ticks for the delay instruction. arm_i clears the
// count; while run_i is high each tick adds one. hit_o flags the tick
// that makes the count equal to target_i. Assumes target_i > 0 while running.
module useq_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [DW-1:0] target_i,
    output logic          hit_o
);

    logic [DW-1:0] cnt_q;

    // Tick counter, restarted at each delay instruction
    always_ff @(posedge clk) begin
        if (!rst_n || arm_i) cnt_q <= '0;
        else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
    end

    // Final tick detection
    always_comb hit_o = run_i && tick_i && (cnt_q + 1'b1 == target_i);

    AST_DLY_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q < target_i); // R12

endmodule

// File: rtl/pport_useq.sv
// Module: pport_useq
// Microinstruction engine that drives a parallel port register block.
// Assumes synchronous one-cycle reads on instruction and buffer memory,
// a combinational register read port and IA_W <= 8.
module pport_useq
    import pport_useq_pkg::*;
#(
    parameter int IA_W = 6,
    parameter int DLY_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [IA_W-1:0] start_addr_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [7:0]      ret_code_o,
    output logic            err_o,
    output logic [IA_W-1:0] imem_addr_o,
    input  logic [IW-1:0]   imem_rdata_i,
    output logic [7:0]      buf_addr_o,
    output logic            buf_we_o,
    output logic [7:0]      buf_wdata_o,
    input  logic [7:0]      buf_rdata_i,
    output logic [1:0]      reg_sel_o,
    output logic            reg_we_o,
    output logic [7:0]      reg_wdata_o,
    input  logic [7:0]      reg_rdata_i,
    input  logic            tick_us_i
);

    state_e          state_q;
    logic [IA_W-1:0] pc_q, ret_pc_q;
    logic            in_sub_q;
    logic [IW-1:0]   ir_q, word;
    logic [7:0]      loop_q, ptr_q, rep_q, loop_dec;
    logic [4:0]      op;
    logic [1:0]      sel;
    logic [7:0]      fa, fb, fc;
    logic [IA_W-1:0] pc_inc, pc_tgt;
    logic            take, dly_hit, exec;

    // Instruction word: live memory data in EXEC, latched copy afterwards
    always_comb begin
        word     = (state_q == ST_EXEC) ? imem_rdata_i : ir_q;
        op       = word[31:27];
        sel      = word[25:24];
        fa       = word[23:16];
        fb       = word[15:8];
        fc       = word[7:0];
        exec     = (state_q == ST_EXEC);
        pc_inc   = pc_q + 1'b1;
        pc_tgt   = pc_inc + fc[IA_W-1:0];
        loop_dec = loop_q - 8'd1;
    end

    useq_cond u_cond (
        .op_i(op), .status_i(reg_rdata_i), .mask_a_i(fa), .mask_b_i(fb),
        .take_o(take)
    );

    useq_delay #(.DW(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n),
        .arm_i(exec && op == OP_DELAY), .run_i(state_q == ST_WAIT),
        .tick_i(tick_us_i), .target_i(DLY_W'({fb, fc})), .hit_o(dly_hit)
    );

    // Memory and port register access strobes
    always_comb begin
        imem_addr_o = pc_q;
        busy_o      = (state_q != ST_IDLE);
        buf_addr_o  = (exec && op == OP_FETCH) ? fc : ptr_q;
        buf_we_o    = (exec && op == OP_FETCH) ||
                      (state_q == ST_REP && op == OP_PFETCH && rep_q != 8'd0);
        buf_wdata_o = reg_rdata_i & ((op == OP_FETCH) ? fa : fb);
        reg_sel_o   = (exec && (op == OP_BRANY1 || op == OP_BRANY0 ||
                                op == OP_BRSTATE)) ? SEL_STATUS : sel;
        reg_we_o    = 1'b0;
        reg_wdata_o = buf_rdata_i;
        if (exec && op == OP_MODIFY) begin
            reg_we_o    = 1'b1;
            reg_wdata_o = (reg_rdata_i | fa) & ~fb;
        end else if (exec && op == OP_WRITE) begin
            reg_we_o    = 1'b1;
            reg_wdata_o = fa;
        end else if (state_q == ST_PWR) begin
            reg_we_o    = 1'b1;
        end
        if (sel == SEL_STATUS) reg_we_o = 1'b0;
    end

    // Sequencer state, program counter and execution context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pc_q       <= '0;
            ret_pc_q   <= '0;
            in_sub_q   <= 1'b0;
            ir_q       <= '0;
            loop_q     <= '0;
            ptr_q      <= '0;
            rep_q      <= '0;
            done_o     <= 1'b0;
            ret_code_o <= '0;
            err_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    pc_q       <= start_addr_i;
                    in_sub_q   <= 1'b0;
                    loop_q     <= '0;
                    ptr_q      <= '0;
                    ret_code_o <= '0;
                    err_o      <= 1'b0;
                    state_q    <= ST_FETCH;
                end
                ST_FETCH: state_q <= ST_EXEC;
                ST_EXEC: begin
                    ir_q    <= imem_rdata_i;
                    pc_q    <= pc_inc;
                    state_q <= ST_FETCH;
                    unique case (op)
                        OP_FETCH, OP_MODIFY, OP_WRITE: ;
                        OP_DELAY: if ({fb, fc} != 16'd0) begin
                            pc_q    <= pc_q;
                            state_q <= ST_WAIT;
                        end
                        OP_LDCNT: loop_q <= fc;
                        OP_DECBR: begin
                            loop_q <= loop_dec;
                            if (loop_dec != 8'd0) pc_q <= pc_tgt;
                        end
                        OP_BRANY1, OP_BRANY0, OP_BRSTATE:
                            if (take) pc_q <= pc_tgt;
                        OP_LDPTR: ptr_q <= fc;
                        OP_RETURN: begin
                            ret_code_o <= fc;
                            done_o     <= 1'b1;
                            state_q    <= ST_IDLE;
                        end
                        OP_SUBRET: if (in_sub_q) begin
                            pc_q     <= ret_pc_q;
                            in_sub_q <= 1'b0;
                        end else begin
                            err_o   <= 1'b1;
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        OP_CALL: if (!in_sub_q) begin
                            ret_pc_q <= pc_inc;
                            in_sub_q <= 1'b1;
                            pc_q     <= fc[IA_W-1:0];
                        end else begin
                            err_o   <= 1'b1;
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        OP_PWRITE, OP_PFETCH: begin
                            rep_q   <= fa;
                            pc_q    <= pc_q;
                            state_q <= ST_REP;
                        end
                        default: begin
                            err_o   <= 1'b1;
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    endcase
                end
                ST_WAIT: if (dly_hit) begin
                    pc_q    <= pc_inc;
                    state_q <= ST_FETCH;
                end
                ST_REP: begin
                    if (rep_q == 8'd0) begin
                        pc_q    <= pc_inc;
                        state_q <= ST_FETCH;
                    end else if (op == OP_PFETCH) begin
                        ptr_q <= ptr_q + 8'd1;
                        rep_q <= rep_q - 8'd1;
                    end else begin
                        state_q <= ST_PWR;
                    end
                end
                ST_PWR: begin
                    ptr_q   <= ptr_q + 8'd1;
                    rep_q   <= rep_q - 8'd1;
                    state_q <= ST_REP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R1
    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> reg_sel_o != SEL_STATUS); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REP && buf_we_o) |=> ptr_q == $past(ptr_q) + 8'd1); // R5
    AST_CALL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_CALL && in_sub_q) |=> (done_o && err_o)); // R11

endmodule

// File: tb/pport_useq_tb.sv
// Bench: memories and port registers modelled behaviourally; results
// compared with an instruction-level reference model.
module pport_useq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IA_W = 6;
    localparam int DEPTH = 1 << IA_W;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
    logic [IA_W-1:0] start_addr = '0;
    logic busy, done, err;
    logic [7:0] code;
    logic [IA_W-1:0] imem_addr;
    logic [31:0] imem_q;
    logic [7:0] buf_addr, buf_wdata, buf_q, reg_wdata, reg_rdata;
    logic buf_we, reg_we;
    logic [1:0] reg_sel;

    logic [31:0] imem [DEPTH];
    logic [7:0]  bmem [256];
    logic [7:0]  regs [4];
    logic [7:0]  status = 8'h00;
    logic [7:0]  m_regs [4];
    logic [7:0]  m_buf [256];

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_useq #(.IA_W(IA_W), .DLY_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .busy_o(busy), .done_o(done), .ret_code_o(code), .err_o(err),
        .imem_addr_o(imem_addr), .imem_rdata_i(imem_q),
        .buf_addr_o(buf_addr), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
        .buf_rdata_i(buf_q), .reg_sel_o(reg_sel), .reg_we_o(reg_we),
        .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .tick_us_i(tick)
    );

    assign reg_rdata = (reg_sel == 2'd1) ? status : regs[reg_sel];

    always @(posedge clk) begin
        imem_q <= imem[imem_addr];
        buf_q  <= bmem[buf_addr];
        if (buf_we) bmem[buf_addr] <= buf_wdata;
        if (reg_we && reg_sel != 2'd1) regs[reg_sel] <= reg_wdata;
    end

    function automatic logic [31:0] ins(input int op, input int sel,
                                        input int a, input int b, input int c);
        return {op[4:0], 1'b0, sel[1:0], a[7:0], b[7:0], c[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Instruction-level reference model of the requirements
    task automatic run_model(input int sa, output int mcode, output bit merr);
        int pc = sa, ret = 0, steps = 0;
        bit insub = 0, fin = 0;
        logic [7:0] lp = 0, ptr = 0, rv;
        mcode = 0; merr = 0;
        while (!fin && steps < 5000) begin
            logic [31:0] w = imem[pc];
            int op = int'(w[31:27]);
            int sel = int'(w[25:24]);
            logic [7:0] a = w[23:16], b = w[15:8], c = w[7:0];
            int nxt = (pc + 1) % DEPTH;
            int tgt = (pc + 1 + int'($signed(c))) & (DEPTH - 1);
            rv = (sel == 1) ? status : m_regs[sel];
            steps++;
            pc = nxt;
            case (op)
                2: m_buf[c] = rv & a;
                3: if (sel != 1) m_regs[sel] = (rv | a) & ~b;
                4: if (sel != 1) m_regs[sel] = a;
                5: ;
                6: lp = c;
                7: begin lp = lp - 1; if (lp != 0) pc = tgt; end
                8: if ((status & a) != 0) pc = tgt;
                9: if ((~status & a) != 0) pc = tgt;
                10: begin mcode = int'(c); fin = 1; end
                12: ptr = c;
                14: if ((status & a) == a && (status & b) == 0) pc = tgt;
                15: if (insub) begin pc = ret; insub = 0; end
                    else begin merr = 1; fin = 1; end
                16: if (!insub) begin ret = nxt; insub = 1; pc = int'(c) % DEPTH; end
                    else begin merr = 1; fin = 1; end
                17: for (int k = 0; k < int'(a); k++) begin
                        if (sel != 1) m_regs[sel] = m_buf[ptr];
                        ptr++;
                    end
                18: for (int k = 0; k < int'(a); k++) begin
                        m_buf[ptr] = rv & b;
                        ptr++;
                    end
                default: begin merr = 1; fin = 1; end
            endcase
        end
    endtask

    // Runs the DUT from sa and compares all results with the model
    task automatic run_cmp(input int sa, input string req);
        int mcode, cyc = 0, diffs = 0;
        bit merr;
        foreach (m_regs[i]) m_regs[i] = regs[i];
        foreach (m_buf[i]) m_buf[i] = bmem[i];
        run_model(sa, mcode, merr);
        @(negedge clk);
        start = 1'b1; start_addr = IA_W'(sa);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        check(done == 1'b1, {req, " done"}, int'(done), 1);
        check(code == 8'(mcode), {req, " code"}, int'(code), mcode);
        check(err == merr, {req, " err"}, int'(err), int'(merr));
        check(regs[0] == m_regs[0], {req, " data reg"}, int'(regs[0]), int'(m_regs[0]));
        check(regs[2] == m_regs[2], {req, " ctrl reg"}, int'(regs[2]), int'(m_regs[2]));
        foreach (bmem[i]) if (bmem[i] !== m_buf[i]) diffs++;
        check(diffs == 0, {req, " buffer"}, diffs, 0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 done one cycle", int'(done), 0);
        check(code == 8'(mcode), "R1 code held", int'(code), mcode);
    endtask

    task automatic clear_prog();
        foreach (imem[i]) imem[i] = ins(10, 0, 0, 0, 8'hEE);
    endtask

    task automatic rand_prog();
        int n = 2 + int'($urandom % 9);
        clear_prog();
        for (int i = 0; i < n; i++) begin
            int k = int'($urandom % 12);
            int s = ($urandom % 2) ? 2 : 0;
            int sa = int'($urandom % 3);
            int ra = int'($urandom % 256), rb = int'($urandom % 256), rc = int'($urandom % 256);
            case (k)
                0: imem[i] = ins(2, sa, ra, 0, rc);
                1: imem[i] = ins(3, s, ra, rb, 0);
                2: imem[i] = ins(4, s, ra, 0, 0);
                3: imem[i] = ins(6, 0, 0, 0, rc);
                4: imem[i] = ins(12, 0, 0, 0, rc);
                5: imem[i] = ins(17, s, ra % 4, 0, 0);
                6: imem[i] = ins(18, sa, ra % 4, rb, 0);
                7: imem[i] = ins(8, 0, ra, 0, rc % 3);
                8: imem[i] = ins(9, 0, ra, 0, rc % 3);
                9: imem[i] = ins(14, 0, ra & 8'h0F, rb & 8'hF0, rc % 3);
                10: imem[i] = ins(7, 0, 0, 0, rc % 3);
                default: imem[i] = ins(3, 1, ra, rb, 0);
            endcase
        end
        for (int i = n; i < n + 3; i++) imem[i] = ins(10, 0, 0, 0, int'($urandom % 256));
    endtask

    initial begin
        void'($urandom(32'd4242));
        foreach (bmem[i]) bmem[i] = 8'(i * 7);
        foreach (regs[i]) regs[i] = 8'h00;
        clear_prog();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && code == 0, "R1 reset state",
              int'({busy, done, err}), 0);

        // R2 R3 R4 R13: modify, write, fetch, return
        clear_prog();
        imem[0] = ins(4, 0, 8'hA5, 0, 0);
        imem[1] = ins(3, 0, 8'h0A, 8'h81, 0);
        imem[2] = ins(2, 0, 8'h3C, 0, 8'h10);
        imem[3] = ins(4, 1, 8'hFF, 0, 0);
        imem[4] = ins(10, 0, 0, 0, 8'h5A);
        status = 8'h42;
        run_cmp(0, "R2 R3 R4 R13");
        check(regs[0] == 8'h2E, "R2 modify result", int'(regs[0]), 8'h2E);
        check(bmem[8'h10] == 8'h2C, "R4 masked fetch", int'(bmem[8'h10]), 8'h2C);

        // R6 R9 R5: backward loop of pointer fetches
        clear_prog();
        regs[0] = 8'h77;
        imem[0] = ins(12, 0, 0, 0, 8'h40);
        imem[1] = ins(6, 0, 0, 0, 3);
        imem[2] = ins(18, 0, 1, 8'hFF, 0);
        imem[3] = ins(7, 0, 0, 0, 8'hFE);
        imem[4] = ins(10, 0, 0, 0, 5);
        run_cmp(0, "R6 R9 loop");
        check(bmem[8'h42] == 8'h77 && bmem[8'h43] != 8'h77, "R5 R6 three trips",
              int'(bmem[8'h43]), 8'h77 * 0);

        // R5: pointer write wraps the pointer past 255
        clear_prog();
        imem[0] = ins(12, 0, 0, 0, 8'hFF);
        imem[1] = ins(17, 2, 2, 0, 0);
        imem[2] = ins(10, 0, 0, 0, 1);
        run_cmp(0, "R5 wrap");
        check(regs[2] == bmem[0], "R5 wrap last", int'(regs[2]), int'(bmem[0]));

        // R7 R8: branch decisions
        clear_prog();
        status = 8'b0101_0000;
        imem[0] = ins(8, 0, 8'h20, 0, 2);
        imem[1] = ins(9, 0, 8'h10, 0, 2);
        imem[2] = ins(14, 0, 8'h50, 8'h20, 1);
        imem[3] = ins(10, 0, 0, 0, 8'h33);
        imem[4] = ins(10, 0, 0, 0, 8'h44);
        run_cmp(0, "R7 R8");
        check(code == 8'h44, "R8 all-match taken", int'(code), 8'h44);

        // R10: call and resume
        clear_prog();
        imem[3] = ins(16, 0, 0, 0, 8);
        imem[4] = ins(4, 0, 8'h11, 0, 0);
        imem[5] = ins(10, 0, 0, 0, 7);
        imem[8] = ins(4, 2, 8'h22, 0, 0);
        imem[9] = ins(15, 0, 0, 0, 0);
        run_cmp(3, "R10 call");
        check(regs[0] == 8'h11 && regs[2] == 8'h22, "R10 both writes", int'(regs[2]), 8'h22);

        // R11: nested call, stray subreturn, undefined opcode
        clear_prog();
        imem[0] = ins(16, 0, 0, 0, 2);
        imem[2] = ins(16, 0, 0, 0, 4);
        run_cmp(0, "R11 nested");
        check(err == 1 && code == 0, "R11 nested err", int'(err), 1);
        clear_prog();
        imem[0] = ins(15, 0, 0, 0, 0);
        run_cmp(0, "R11 subret");
        clear_prog();
        imem[0] = ins(11, 0, 0, 0, 0);
        run_cmp(0, "R11 undefined");
        check(err == 1, "R11 undefined err", int'(err), 1);

        // R12: delay of 5 ticks, and a zero delay
        clear_prog();
        imem[0] = ins(5, 0, 0, 0, 0);
        imem[1] = ins(5, 0, 0, 0, 5);
        imem[2] = ins(10, 0, 0, 0, 9);
        @(negedge clk); start = 1; start_addr = 0;
        @(negedge clk); start = 0;
        repeat (12) @(negedge clk);
        for (int t = 0; t < 4; t++) begin
            tick = 1; @(negedge clk); tick = 0; repeat (2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check(busy == 1, "R12 still waiting after 4 ticks", int'(busy), 1);
        tick = 1; @(negedge clk); tick = 0;
        begin
            int w = 0;
            while (!done && w < 10) begin @(negedge clk); w++; end
        end
        check(done == 1 && code == 9, "R12 ends after 5th tick", int'(code), 9);
        @(negedge clk);

        // Random programs against the model
        for (int r = 0; r < 60; r++) begin
            status = 8'($urandom);
            regs[0] = 8'($urandom); regs[2] = 8'($urandom);
            rand_prog();
            run_cmp(0, "R2-mix R5 R7 R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule